// File: doc/BRIEF.md
# Burst beat address generator

This block works out the byte address of each beat of a memory-mapped burst. A requester presents a start address, a length field (one less than the number of beats), a beat-size field and a burst kind, then pulses a load strobe. From the next cycle the block shows the first beat address and keeps a beat count. Each step pulse accepted during the burst moves it to the address of the next beat. The block marks the final beat and ends the burst when that beat is stepped.

Three burst kinds are supported. A constant burst stays on the start address. An incrementing burst adds the beat size for each beat. A wrapping burst steps forward inside a window whose size is beat size times beat count, aligned to that size, and wraps back to the bottom of the window when it reaches the top. Requests the block cannot serve raise an error flag: the reserved kind, an oversized beat, or a wrapping length other than 2, 4, 8 or 16 beats. Such a burst still counts its beats but holds the address at the start value. The block neither moves data nor checks page crossings.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, active_o, last_o and err_o are 0 and addr_o is 0.
- R2: In the cycle after a load_i pulse, active_o is 1, addr_o equals the captured start address and the beat count is zero. This holds even when a burst is already running. load_i takes priority over a step_i in the same cycle.
- R3: A burst has len_i+1 beats. last_o is 1 only on the final beat. A step_i on the final beat makes active_o 0 in the next cycle and leaves addr_o unchanged.
- R4: With kind_i = 2'b00 (constant), every beat address equals the start address.
- R5: With kind_i = 2'b01 (incrementing), beat i is at start + i * 2^size_i.
- R6: With kind_i = 2'b10 (wrapping), beat i is at B + ((start + i * 2^size_i) mod W). W = (len_i+1) * 2^size_i and B is the start address rounded down to a multiple of W.
- R7: A step_i while active_o is 0 has no effect: addr_o holds and active_o stays 0.
- R8: kind_i = 2'b11 (reserved) sets err_o from the cycle after load until the next load.
- R9: A wrapping request whose len_i is not 1, 3, 7 or 15 sets err_o. Any errored burst still runs len_i+1 beats but keeps addr_o at the start address.
- R10: A size_i larger than log2(DATA_BYTES) sets err_o. (The beat size is 2^size_i bytes.)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture a new burst request |
| start_addr_i | input | ADDR_W | Byte address of the first beat |
| len_i | input | LEN_W | Beat count minus one |
| size_i | input | 3 | log2 of bytes per beat |
| kind_i | input | 2 | 00 constant, 01 incrementing, 10 wrapping, 11 reserved |
| step_i | input | 1 | Current beat accepted; move to the next |
| addr_o | output | ADDR_W | Address of the current beat |
| active_o | output | 1 | A burst is in progress |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | The request held is illegal |

## Verification
The hardest case to reach is the wrap fold inside a window whose start is not at the bottom of that window. The fold occurs only on the beat that crosses the top. For that reason the wrapping tests start part-way up their windows, for example at 0x38 in a 16-byte window and at 0x1018 in a 64-byte window, so that the fold happens in the middle of the burst. A second hard case is a reload while a burst is running, with a step in the same cycle. The bench drives both strobes on one edge and checks that the new start address wins.

// File: rtl/burst_pkg.sv
package burst_pkg;
   typedef enum logic [1:0] {
      BK_CONST = 2'b00,
      BK_INCR  = 2'b01,
      BK_WRAP  = 2'b10,
      BK_RSVD  = 2'b11
   } burst_kind_e;
endpackage

// File: rtl/burst_req_check.sv
module burst_req_check
   import burst_pkg::*;
#(
   parameter int LEN_W    = 8,
   parameter int MAX_SIZE = 3
) (
   input  logic [LEN_W-1:0] len,
   input  logic [2:0]       size,
   input  burst_kind_e      kind,
   output logic             bad,
   output logic [2:0]       wrap_lg
);
   if (LEN_W < 4) begin : g_len_chk
      $error("LEN_W must allow 16-beat wrap bursts");
   end
   if (MAX_SIZE > 7) begin : g_size_chk
      $error("MAX_SIZE exceeds size field range");
   end

   always_comb begin
      case (len)
         LEN_W'(1):  wrap_lg = 3'd1;
         LEN_W'(3):  wrap_lg = 3'd2;
         LEN_W'(7):  wrap_lg = 3'd3;
         LEN_W'(15): wrap_lg = 3'd4;
         default:    wrap_lg = 3'd0;
      endcase
   end

   always_comb begin
      bad = 1'b0;
      if (kind == BK_RSVD) bad = 1'b1;
      if (kind == BK_WRAP && wrap_lg == 3'd0) bad = 1'b1;
      if (size > 3'(MAX_SIZE)) bad = 1'b1;
   end
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
   import burst_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] cur,
   input  burst_kind_e       kind,
   input  logic [2:0]        size,
   input  logic [ADDR_W-1:0] wmask,
   input  logic              hold,
   output logic [ADDR_W-1:0] nxt
);
   logic [ADDR_W-1:0] stride;
   logic [ADDR_W-1:0] sum;

   assign stride = ADDR_W'(1) << size;
   assign sum    = cur + stride;

   always_comb begin
      if (hold) begin
         nxt = cur;
      end else begin
         case (kind)
            BK_INCR: nxt = sum;
            BK_WRAP: nxt = (cur & ~wmask) | (sum & wmask);
            default: nxt = cur;
         endcase
      end
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   input  logic             step,
   output logic             active,
   output logic             last
);
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         len_q  <= '0;
      end else if (load) begin
         active <= 1'b1;
         cnt    <= '0;
         len_q  <= len;
      end else if (active && step) begin
         if (cnt == len_q) active <= 1'b0;
         else              cnt    <= cnt + LEN_W'(1);
      end
   end

   assign last = active && (cnt == len_q);

   assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (active && cnt == '0));
   assert_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && step && last && !load) |=> !active);
   assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && step && !last && !load) |=> (active && cnt == $past(cnt) + LEN_W'(1)));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 8,
   parameter int DATA_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [2:0]        size_i,
   input  logic [1:0]        kind_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              active_o,
   output logic              last_o,
   output logic              err_o
);
   localparam int MAX_SIZE = $clog2(DATA_BYTES);

   if (ADDR_W < 12) begin : g_addr_chk
      $error("ADDR_W too small for the widest wrap window");
   end
   if ((1 << MAX_SIZE) != DATA_BYTES) begin : g_bytes_chk
      $error("DATA_BYTES must be a power of two");
   end

   burst_kind_e       kind_in;
   burst_kind_e       kind_q;
   logic [2:0]        size_q;
   logic [ADDR_W-1:0] mask_q;
   logic [ADDR_W-1:0] base_q;
   logic              bad;
   logic [2:0]        wrap_lg;
   logic [ADDR_W-1:0] mask_d;
   logic [ADDR_W-1:0] nxt;

   assign kind_in = burst_kind_e'(kind_i);
   assign mask_d  = (ADDR_W'(1) << ({1'b0, wrap_lg} + {1'b0, size_i})) - ADDR_W'(1);

   burst_req_check #(.LEN_W(LEN_W), .MAX_SIZE(MAX_SIZE)) u_chk (
      .len     (len_i),
      .size    (size_i),
      .kind    (kind_in),
      .bad     (bad),
      .wrap_lg (wrap_lg)
   );

   burst_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_i),
      .len    (len_i),
      .step   (step_i),
      .active (active_o),
      .last   (last_o)
   );

   burst_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
      .cur   (addr_o),
      .kind  (kind_q),
      .size  (size_q),
      .wmask (mask_q),
      .hold  (err_o),
      .nxt   (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         kind_q <= BK_CONST;
         size_q <= '0;
         mask_q <= '0;
         base_q <= '0;
         err_o  <= 1'b0;
      end else if (load_i) begin
         addr_o <= start_addr_i;
         kind_q <= kind_in;
         size_q <= size_i;
         mask_q <= mask_d;
         base_q <= start_addr_i & ~mask_d;
         err_o  <= bad;
      end else if (active_o && step_i && !last_o) begin
         addr_o <= nxt;
      end
   end

   assert_const_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && step_i && !load_i && kind_q == BK_CONST) |=> $stable(addr_o));
   assert_incr_stride_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && step_i && !last_o && !load_i && !err_o && kind_q == BK_INCR)
      |=> (addr_o == $past(addr_o) + (ADDR_W'(1) << size_q)));
   assert_wrap_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !err_o && kind_q == BK_WRAP) |-> ((addr_o & ~mask_q) == base_q));
   assert_idle_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && !load_i) |=> ($stable(addr_o) && !active_o));
   assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && err_o && step_i && !load_i) |=> $stable(addr_o));
   assert_last_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> active_o);
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [31:0] start_addr_i = '0;
   logic [7:0]  len_i = '0;
   logic [2:0]  size_i = '0;
   logic [1:0]  kind_i = '0;
   logic        step_i = 1'b0;
   logic [31:0] addr_o;
   logic        active_o, last_o, err_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   burst_addr_gen #(.ADDR_W(32), .LEN_W(8), .DATA_BYTES(8)) u0 (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
      .len_i(len_i), .size_i(size_i), .kind_i(kind_i), .step_i(step_i),
      .addr_o(addr_o), .active_o(active_o), .last_o(last_o), .err_o(err_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_addr(input logic [31:0] st, input int len,
                                            input int size, input int kind, input bit er, input int i);
      logic [31:0] b, w;
      b = 32'd1 << size;
      if (er || kind == 0) return st;
      if (kind == 1) return st + 32'(i) * b;
      w = 32'(len + 1) * b;
      return (st & ~(w - 1)) + ((st + 32'(i) * b) % w);
   endfunction

   task automatic do_load(input logic [31:0] st, input int len, input int size, input int kind, input bit with_step);
      @(negedge clk);
      start_addr_i = st; len_i = 8'(len); size_i = 3'(size); kind_i = 2'(kind);
      load_i = 1'b1; step_i = with_step;
      @(negedge clk);
      load_i = 1'b0; step_i = 1'b0;
   endtask

   task automatic do_step();
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
   endtask

   task automatic run_burst(input string req, input logic [31:0] st, input int len,
                            input int size, input int kind, input bit er);
      logic [31:0] e;
      do_load(st, len, size, kind, 1'b0);
      chk(active_o == 1'b1, "R2", 32'(active_o), 32'd1);
      chk(err_o == er, er ? "R8/R9/R10" : req, 32'(err_o), 32'(er));
      for (int i = 0; i <= len; i++) begin
         e = ref_addr(st, len, size, kind, er, i);
         chk(addr_o == e, req, addr_o, e);
         chk(last_o == (i == len), "R3", 32'(last_o), 32'(i == len));
         chk(active_o == 1'b1, "R3", 32'(active_o), 32'd1);
         do_step();
      end
      chk(active_o == 1'b0, "R3", 32'(active_o), 32'd0);
      chk(addr_o == e, "R3", addr_o, e);
   endtask

   task automatic t_reset();
      chk(active_o == 1'b0, "R1", 32'(active_o), 32'd0);
      chk(last_o == 1'b0, "R1", 32'(last_o), 32'd0);
      chk(err_o == 1'b0, "R1", 32'(err_o), 32'd0);
      chk(addr_o == 32'd0, "R1", addr_o, 32'd0);
   endtask

   task automatic t_idle_step();
      logic [31:0] held;
      held = addr_o;
      do_step();
      do_step();
      chk(addr_o == held, "R7", addr_o, held);
      chk(active_o == 1'b0, "R7", 32'(active_o), 32'd0);
   endtask

   task automatic t_reload();
      do_load(32'h200, 7, 2, 1, 1'b0);
      do_step();
      do_step();
      chk(addr_o == 32'h208, "R5", addr_o, 32'h208);
      do_load(32'h700, 1, 3, 1, 1'b1);
      chk(addr_o == 32'h700, "R2", addr_o, 32'h700);
      chk(last_o == 1'b0, "R2", 32'(last_o), 32'd0);
      do_step();
      chk(addr_o == 32'h708, "R2", addr_o, 32'h708);
      chk(last_o == 1'b1, "R3", 32'(last_o), 32'd1);
      do_step();
      chk(active_o == 1'b0, "R3", 32'(active_o), 32'd0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      #12 rst_n = 1'b1;
      @(negedge clk);
      t_reset();                                   // R1
      t_idle_step();                               // R7
      run_burst("R5", 32'h0, 3, 2, 1, 1'b0);       // incrementing, 4-byte beats
      run_burst("R5", 32'h103, 2, 0, 1, 1'b0);     // byte beats, odd start
      run_burst("R4", 32'h4C, 4, 3, 0, 1'b0);      // constant
      run_burst("R6", 32'h38, 3, 2, 2, 1'b0);      // wrap mid-window, 16-byte window
      run_burst("R6", 32'h1018, 7, 3, 2, 1'b0);    // wrap, 64-byte window
      run_burst("R6", 32'h5E, 15, 1, 2, 1'b0);     // wrap, 16 beats of 2 bytes
      run_burst("R6", 32'h24, 1, 2, 2, 1'b0);      // wrap, 2 beats
      run_burst("R3", 32'h80, 0, 2, 1, 1'b0);      // single beat
      run_burst("R8", 32'h90, 1, 2, 3, 1'b1);      // reserved kind
      run_burst("R9", 32'hA4, 2, 2, 2, 1'b1);      // wrap of 3 beats
      run_burst("R10", 32'hC0, 1, 4, 1, 1'b1);     // beat wider than bus
      t_reload();                                  // R2 reload with step
      t_idle_step();                               // R7 after burst
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule